// File: doc/BRIEF.md
# Sector Readback Verifier with Bounded Retry

This block sits behind a flash programming engine. It checks each sector after that sector has been written and read back. Read-back bytes arrive one at a time on a valid strobe. For each byte the block presents the byte's offset within the sector on `ref_addr` to an external reference buffer. The buffer is a synchronous-read RAM that answers one clock later. The block compares the two bytes in the following cycle.

After the whole sector has been seen, or after a programmable window of clock cycles has elapsed, the block emits a one-cycle result pulse. The pulse carries the verdict, the sector index and the updated failure count. In the same cycle it emits a command to the frame sender: either advance to the next sector or program the same sector again. A failure count that reaches the limit stops the run with a fatal flag. A pass on the final sector stops the run with a success flag. Both flags, and `done`, stay set until the next `start`.

Top module: `sector_readback_verifier`

## Requirements
- R1: After reset, and after `start` in an idle or stopped state, `done`, `success` and `fatal` are 0 and checking begins at sector 0 with a failure count of 0.
- R2: The bytes of a sector are taken in ascending offset order. `ref_addr` shows the offset of the next byte to be taken, and the byte is compared with the `ref_data` value returned one cycle after that address.
- R3: A sector passes only when all `SECTOR_BYTES` bytes match. A single differing byte at any offset, including the first (0) and the last (`SECTOR_BYTES`-1), makes it fail.
- R4: On a fail that does not reach the limit, the block pulses `cmd_valid` with `cmd_retry`=1 and `cmd_sector` equal to the failed sector, and the failure count increments.
- R5: On a pass of a sector other than `last_sector`, the failure count returns to 0 and the block pulses `cmd_valid` with `cmd_retry`=0 and `cmd_sector` equal to the passed sector plus one.
- R6: When the failure count of one sector reaches `MAX_FAILS` (default 20), the block sets `done` and `fatal`, issues no command and stops.
- R7: A pass of `last_sector` sets `done` and `success`, issues no command and stops.
- R8: Each sector verdict appears as a single-cycle `res_valid` pulse carrying `res_pass`, `res_sector`, and `res_fails` (the failure count after the update, 0 on a pass).
- R9: Bytes that arrive once a sector's full count has been taken, or while stopped, are ignored. `ref_addr` is 0 again when the next sector window opens.
- R10: A sector window lasts `timeout_limit` cycles from its first cycle. If the full count has not arrived by then, the sector fails, and `res_valid` rises `timeout_limit`+1 cycles after the window opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run at sector 0 (taken when idle or stopped) |
| last_sector | input | SECTOR_W | Index of the final sector of the run |
| timeout_limit | input | TIMER_W | Window length in cycles per sector, at least 1 |
| rb_valid | input | 1 | Read-back byte strobe |
| rb_data | input | 8 | Read-back byte |
| ref_addr | output | log2(SECTOR_BYTES) | Offset of the next expected byte in the reference buffer |
| ref_data | input | 8 | Reference byte, one cycle after `ref_addr` |
| cmd_valid | output | 1 | Command pulse to the frame sender |
| cmd_retry | output | 1 | 1: program the same sector again, 0: advance |
| cmd_sector | output | SECTOR_W | Sector the command refers to |
| res_valid | output | 1 | Per-sector verdict pulse |
| res_pass | output | 1 | Verdict: 1 pass, 0 fail |
| res_sector | output | SECTOR_W | Sector the verdict belongs to |
| res_fails | output | log2(MAX_FAILS+1) | Failure count after this verdict |
| done | output | 1 | Run finished (sticky until start) |
| success | output | 1 | Run finished with every sector passed |
| fatal | output | 1 | Run stopped on the failure limit |

## Verification
The properties assume that `ref_data` is the reference byte at the offset shown on `ref_addr` one cycle earlier. They also assume that `last_sector` and `timeout_limit` stay constant while a run is active and that `timeout_limit` is at least 1. The bench meets these assumptions with a registered reference-memory model indexed by the sector it is currently feeding, and it sets both configuration inputs only before each `start`. Random byte values and random idle gaps stay short enough that a full sector always fits inside the window, except in the directed timeout case, which deliberately sends a partial sector.

// File: rtl/rbv_pkg.sv
package rbv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_EVAL  = 3'd3,
    ST_STOP  = 3'd4
  } rbv_state_t;
endpackage

// File: rtl/rbv_byte_cmp.sv
module rbv_byte_cmp #(
  parameter int SECTOR_BYTES = 4096
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            en,
  input  logic                            rb_valid,
  input  logic [7:0]                      rb_data,
  input  logic [7:0]                      ref_data,
  output logic [$clog2(SECTOR_BYTES)-1:0] ref_addr,
  output logic                            last_take,
  output logic                            mismatch
);
  localparam int AW = $clog2(SECTOR_BYTES);
  localparam logic [AW:0] FULL = (AW+1)'(SECTOR_BYTES);
  localparam logic [AW:0] LAST = (AW+1)'(SECTOR_BYTES - 1);

  logic [AW:0] taken;
  logic        pipe_v;
  logic [7:0]  pipe_d;
  logic        take;

  assign take      = en && rb_valid && (taken < FULL);
  assign last_take = take && (taken == LAST);
  assign ref_addr  = taken[AW-1:0];

  // One stage of delay lines the byte up with the registered reference read.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      taken    <= '0;
      pipe_v   <= 1'b0;
      pipe_d   <= '0;
      mismatch <= 1'b0;
    end else begin
      if (take) taken <= taken + 1'b1;
      pipe_v <= take;
      pipe_d <= rb_data;
      if (pipe_v && (pipe_d != ref_data)) mismatch <= 1'b1;
    end
  end
endmodule

// File: rtl/rbv_window_timer.sv
module rbv_window_timer #(
  parameter int TIMER_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [TIMER_W-1:0] limit,
  output logic               expired
);
  logic [TIMER_W-1:0] ticks;

  assign expired = en && (ticks == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) ticks <= '0;
    else            ticks <= ticks + 1'b1;
  end
endmodule

// File: rtl/rbv_retry_ctrl.sv
module rbv_retry_ctrl
  import rbv_pkg::*;
#(
  parameter int SECTOR_W  = 12,
  parameter int MAX_FAILS = 20
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               start,
  input  logic [SECTOR_W-1:0]                last_sector,
  input  logic                               last_take,
  input  logic                               expired,
  input  logic                               mismatch,
  output logic                               collect,
  output logic                               cmp_clr,
  output logic                               cmd_valid,
  output logic                               cmd_retry,
  output logic [SECTOR_W-1:0]                cmd_sector,
  output logic                               res_valid,
  output logic                               res_pass,
  output logic [SECTOR_W-1:0]                res_sector,
  output logic [$clog2(MAX_FAILS+1)-1:0]     res_fails,
  output logic                               done,
  output logic                               success,
  output logic                               fatal
);
  localparam int FW = $clog2(MAX_FAILS + 1);
  localparam logic [FW-1:0] LIMIT = FW'(MAX_FAILS);

  rbv_state_t          state;
  logic [SECTOR_W-1:0] sector;
  logic [FW-1:0]       fails;
  logic [FW-1:0]       fails_inc;
  logic                timed_out;
  logic                verdict;

  assign collect   = (state == ST_RUN);
  assign cmp_clr   = (state != ST_RUN) && (state != ST_DRAIN);
  assign fails_inc = fails + 1'b1;
  assign verdict   = !mismatch && !timed_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sector     <= '0;
      fails      <= '0;
      timed_out  <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_retry  <= 1'b0;
      cmd_sector <= '0;
      res_valid  <= 1'b0;
      res_pass   <= 1'b0;
      res_sector <= '0;
      res_fails  <= '0;
      done       <= 1'b0;
      success    <= 1'b0;
      fatal      <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      res_valid <= 1'b0;
      case (state)
        ST_IDLE, ST_STOP: begin
          if (start) begin
            state     <= ST_RUN;
            sector    <= '0;
            fails     <= '0;
            timed_out <= 1'b0;
            done      <= 1'b0;
            success   <= 1'b0;
            fatal     <= 1'b0;
          end
        end
        ST_RUN: begin
          if (last_take) begin
            state <= ST_DRAIN;
          end else if (expired) begin
            timed_out <= 1'b1;
            state     <= ST_EVAL;
          end
        end
        ST_DRAIN: state <= ST_EVAL;
        ST_EVAL: begin
          res_valid  <= 1'b1;
          res_pass   <= verdict;
          res_sector <= sector;
          timed_out  <= 1'b0;
          if (verdict) begin
            fails     <= '0;
            res_fails <= '0;
            if (sector == last_sector) begin
              done    <= 1'b1;
              success <= 1'b1;
              state   <= ST_STOP;
            end else begin
              sector     <= sector + 1'b1;
              cmd_valid  <= 1'b1;
              cmd_retry  <= 1'b0;
              cmd_sector <= sector + 1'b1;
              state      <= ST_RUN;
            end
          end else begin
            fails     <= fails_inc;
            res_fails <= fails_inc;
            if (fails_inc == LIMIT) begin
              done  <= 1'b1;
              fatal <= 1'b1;
              state <= ST_STOP;
            end else begin
              cmd_valid  <= 1'b1;
              cmd_retry  <= 1'b1;
              cmd_sector <= sector;
              state      <= ST_RUN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sector_readback_verifier.sv
module sector_readback_verifier #(
  parameter int SECTOR_BYTES = 4096,
  parameter int SECTOR_W     = 12,
  parameter int MAX_FAILS    = 20,
  parameter int TIMER_W      = 24
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [SECTOR_W-1:0]             last_sector,
  input  logic [TIMER_W-1:0]              timeout_limit,
  input  logic                            rb_valid,
  input  logic [7:0]                      rb_data,
  output logic [$clog2(SECTOR_BYTES)-1:0] ref_addr,
  input  logic [7:0]                      ref_data,
  output logic                            cmd_valid,
  output logic                            cmd_retry,
  output logic [SECTOR_W-1:0]             cmd_sector,
  output logic                            res_valid,
  output logic                            res_pass,
  output logic [SECTOR_W-1:0]             res_sector,
  output logic [$clog2(MAX_FAILS+1)-1:0]  res_fails,
  output logic                            done,
  output logic                            success,
  output logic                            fatal
);
  logic collect, cmp_clr, last_take, mismatch, expired;

  rbv_byte_cmp #(.SECTOR_BYTES(SECTOR_BYTES)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .clr       (cmp_clr),
    .en        (collect),
    .rb_valid  (rb_valid),
    .rb_data   (rb_data),
    .ref_data  (ref_data),
    .ref_addr  (ref_addr),
    .last_take (last_take),
    .mismatch  (mismatch)
  );

  rbv_window_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en      (collect),
    .limit   (timeout_limit),
    .expired (expired)
  );

  rbv_retry_ctrl #(.SECTOR_W(SECTOR_W), .MAX_FAILS(MAX_FAILS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .last_sector (last_sector),
    .last_take   (last_take),
    .expired     (expired),
    .mismatch    (mismatch),
    .collect     (collect),
    .cmp_clr     (cmp_clr),
    .cmd_valid   (cmd_valid),
    .cmd_retry   (cmd_retry),
    .cmd_sector  (cmd_sector),
    .res_valid   (res_valid),
    .res_pass    (res_pass),
    .res_sector  (res_sector),
    .res_fails   (res_fails),
    .done        (done),
    .success     (success),
    .fatal       (fatal)
  );
endmodule

// File: rtl/rbv_checker.sv
module rbv_checker #(
  parameter int SECTOR_W  = 12,
  parameter int MAX_FAILS = 20
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           start,
  input logic                           cmd_valid,
  input logic                           cmd_retry,
  input logic [SECTOR_W-1:0]            cmd_sector,
  input logic                           res_valid,
  input logic                           res_pass,
  input logic [SECTOR_W-1:0]            res_sector,
  input logic [$clog2(MAX_FAILS+1)-1:0] res_fails,
  input logic                           done,
  input logic                           success,
  input logic                           fatal
);
  localparam int FW = $clog2(MAX_FAILS + 1);

  AST_RES_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R8
  AST_CMD_NEEDS_RES: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> res_valid); // R8
  AST_RETRY_SAME_SECTOR: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_pass && cmd_valid) |-> (cmd_retry && cmd_sector == res_sector && res_fails != '0)); // R4
  AST_ADVANCE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_pass && cmd_valid) |-> (!cmd_retry && cmd_sector == res_sector + 1'b1 && res_fails == '0)); // R5
  AST_FATAL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(fatal) |-> (res_valid && !res_pass && res_fails == FW'(MAX_FAILS) && !cmd_valid && done)); // R6
  AST_FAILS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    res_fails <= FW'(MAX_FAILS)); // R6
  AST_SUCCESS_ON_PASS: assert property (@(posedge clk) disable iff (rst)
    $rose(success) |-> (res_valid && res_pass && !cmd_valid && done)); // R7
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !res_valid); // R9
  AST_NO_CMD_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid); // R6
endmodule

bind sector_readback_verifier rbv_checker #(.SECTOR_W(SECTOR_W), .MAX_FAILS(MAX_FAILS)) u_rbv_checker (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .cmd_valid  (cmd_valid),
  .cmd_retry  (cmd_retry),
  .cmd_sector (cmd_sector),
  .res_valid  (res_valid),
  .res_pass   (res_pass),
  .res_sector (res_sector),
  .res_fails  (res_fails),
  .done       (done),
  .success    (success),
  .fatal      (fatal)
);

// File: tb/sector_readback_verifier_bench.sv
module sector_readback_verifier_bench;
  localparam int N    = 64;
  localparam int SW   = 4;
  localparam int MF   = 20;
  localparam int TW   = 16;
  localparam int AW   = $clog2(N);
  localparam int FW   = $clog2(MF + 1);
  localparam int NSEC = 16;
  localparam int LIM  = 400;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [SW-1:0] last_sector = '0;
  logic [TW-1:0] timeout_limit = TW'(LIM);
  logic          rb_valid = 1'b0;
  logic [7:0]    rb_data = '0;
  logic [AW-1:0] ref_addr;
  logic [7:0]    ref_data = '0;
  logic          cmd_valid, cmd_retry, res_valid, res_pass, done, success, fatal;
  logic [SW-1:0] cmd_sector, res_sector;
  logic [FW-1:0] res_fails;

  always #2.5 clk = ~clk;

  sector_readback_verifier #(.SECTOR_BYTES(N), .SECTOR_W(SW), .MAX_FAILS(MF), .TIMER_W(TW)) u_sector_readback_verifier (
    .clk(clk), .rst(rst), .start(start), .last_sector(last_sector), .timeout_limit(timeout_limit),
    .rb_valid(rb_valid), .rb_data(rb_data), .ref_addr(ref_addr), .ref_data(ref_data),
    .cmd_valid(cmd_valid), .cmd_retry(cmd_retry), .cmd_sector(cmd_sector),
    .res_valid(res_valid), .res_pass(res_pass), .res_sector(res_sector), .res_fails(res_fails),
    .done(done), .success(success), .fatal(fatal)
  );

  logic [7:0] ref_mem [NSEC][N];
  int feed_sec = 0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int m_sec, m_fails, m_last;

  // Reference buffer model: registered read, one cycle of latency.
  always @(posedge clk) begin
    ref_data <= ref_mem[feed_sec][ref_addr];
    cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pass_f(input int bad, input int nbytes);
    return (bad < 0) && (nbytes == N);
  endfunction

  task automatic send_bytes(input int sec, input int bad, input int nbytes, input int extra);
    for (int i = 0; i < nbytes; i++) begin
      rb_valid = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      rb_valid = 1'b1;
      rb_data  = ref_mem[sec][i] ^ ((i == bad) ? 8'h5A : 8'h00);
      @(negedge clk);
    end
    for (int i = 0; i < extra; i++) begin
      rb_valid = 1'b1;
      rb_data  = ~ref_mem[sec][0];
      @(negedge clk);
    end
    rb_valid = 1'b0;
  endtask

  task automatic wait_result(output bit seen);
    int w = 0;
    seen = 1'b0;
    while (!res_valid && w < 3000) begin
      @(negedge clk);
      w++;
    end
    seen = res_valid;
  endtask

  // Feeds one window for the model's current sector and checks the verdict.
  task automatic do_sector(input int bad, input int nbytes, input int extra, input string req);
    bit p, seen, e_cmd, e_retry, e_done, e_succ, e_fatal;
    int e_fails, e_cmd_sec, t0, lat;
    p = exp_pass_f(bad, nbytes);
    e_cmd = 1'b1; e_retry = 1'b0; e_done = 1'b0; e_succ = 1'b0; e_fatal = 1'b0; e_cmd_sec = m_sec;
    if (p) begin
      e_fails = 0;
      if (m_sec == m_last) begin e_cmd = 1'b0; e_done = 1'b1; e_succ = 1'b1; end
      else e_cmd_sec = m_sec + 1;
    end else begin
      e_fails = m_fails + 1;
      if (e_fails == MF) begin e_cmd = 1'b0; e_done = 1'b1; e_fatal = 1'b1; end
      else e_retry = 1'b1;
    end
    feed_sec = m_sec;
    t0 = cyc;
    send_bytes(m_sec, bad, nbytes, extra);
    wait_result(seen);
    lat = cyc - t0;
    chk(seen, req, "result pulse seen", int'(seen), 1);
    chk(res_pass == p, req, "res_pass", int'(res_pass), int'(p));
    chk(int'(res_sector) == m_sec, "R8", "res_sector", int'(res_sector), m_sec);
    chk(int'(res_fails) == e_fails, "R8", "res_fails", int'(res_fails), e_fails);
    chk(cmd_valid == e_cmd, req, "cmd_valid", int'(cmd_valid), int'(e_cmd));
    if (e_cmd) begin
      chk(cmd_retry == e_retry, req, "cmd_retry", int'(cmd_retry), int'(e_retry));
      chk(int'(cmd_sector) == e_cmd_sec, req, "cmd_sector", int'(cmd_sector), e_cmd_sec);
      chk(ref_addr == '0, "R9", "ref_addr at window open", int'(ref_addr), 0);
    end
    chk(done == e_done && success == e_succ && fatal == e_fatal, req, "done/success/fatal",
        {29'd0, done, success, fatal}, {29'd0, e_done, e_succ, e_fatal});
    if (nbytes < N) chk(lat == LIM + 1, "R10", "timeout latency", lat, LIM + 1);
    m_fails = e_fails;
    if (p && e_cmd) m_sec = m_sec + 1;
  endtask

  task automatic begin_run(input int last);
    last_sector = SW'(last);
    m_sec = 0; m_fails = 0; m_last = last;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!done && !success && !fatal, "R1", "flags cleared by start",
        {29'd0, done, success, fatal}, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < NSEC; s++)
      for (int b = 0; b < N; b++) ref_mem[s][b] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !success && !fatal && !res_valid && !cmd_valid, "R1", "reset outputs",
        {27'd0, done, success, fatal, res_valid, cmd_valid}, 0);
    chk(ref_addr == '0, "R1", "reset ref_addr", int'(ref_addr), 0);

    // Run 1: three sectors with directed corners.
    begin_run(2);
    do_sector(-1, N, 2, "R2");      // clean pass, extra bytes in drain (R9)
    do_sector(0, N, 0, "R3");       // first byte wrong
    do_sector(N - 1, N, 0, "R3");   // last byte wrong
    do_sector(-1, N, 0, "R5");      // pass after retries, count cleared
    do_sector(-1, 10, 0, "R10");    // partial sector times out
    do_sector(int'($urandom_range(1, N - 2)), N, 0, "R4");
    do_sector(-1, N, 0, "R7");      // final sector passes

    // Run 2: one sector failing until the limit.
    begin_run(1);
    for (int k = 0; k < MF; k++)
      do_sector(int'($urandom_range(0, N - 1)), N, 0, (k == MF - 1) ? "R6" : "R4");

    // Stopped: bytes must be ignored.
    send_bytes(0, -1, 5, 0);
    repeat (5) @(negedge clk);
    chk(ref_addr == '0, "R9", "ref_addr while stopped", int'(ref_addr), 0);
    chk(!res_valid && done && fatal, "R9", "no verdict while stopped", int'(res_valid), 0);

    // Run 3: random pass/fail mix over several sectors.
    begin_run(4);
    while (!done) begin
      if ($urandom_range(0, 2) == 0) do_sector(int'($urandom_range(0, N - 1)), N, 0, "R3");
      else do_sector(-1, N, 0, "R2");
    end
    chk(success && int'(res_sector) == 4, "R7", "run 3 ends at last sector", int'(res_sector), 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule